// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks which resident page frame to give up when a new page must be brought in. It uses the second-chance (clock) policy. For every frame it keeps a "recently used" flag and a "modified" flag. A hand pointer walks around the frames in a ring. Memory accesses reported on the access port set the used flag of the frame they touch. A write access also sets the modified flag. A periodic sweep input wipes all used flags at once, so that the flags keep reflecting only recent use.

When the caller raises an eviction request, the hand inspects one frame per clock cycle. A frame whose used flag is set loses the flag and the hand moves on. The first frame found with the flag clear becomes the victim. The block reports the victim's index together with whether it is modified, so the caller knows a write-back is needed. The hand then rests on the frame after the victim. The caller finishes the exchange with a confirm pulse, which wipes both flags of the victim, because the frame now holds a freshly loaded page.

Top module: `clock_victim_sel`

## Requirements
- R1: After synchronous reset all used and modified flags are 0, the hand points at frame 0, `evict_done` is 0, and `victim_idx` and `victim_dirty` read 0.
- R2: A cycle with `acc_valid` high sets the used flag of frame `acc_frame`. If `acc_write` is also high, the modified flag of that frame is set too.
- R3: An eviction request accepted in the idle state starts a sweep on the next cycle, and the sweep inspects one frame per cycle beginning at the hand. A set used flag is cleared and the hand advances by one, wrapping from frame N-1 to frame 0. The first frame with a clear flag is selected. `evict_done` rises 2+k cycles after the cycle in which the request was held, where k is the number of frames skipped.
- R4: If every used flag is set, the sweep goes once around the ring clearing all flags and selects the frame it started from, so k = N.
- R5: After a selection the hand points at the frame that follows the victim, and the next sweep begins there.
- R6: `victim_dirty` equals the victim's modified flag at the moment it was inspected.
- R7: A cycle with `ref_clear` high clears every used flag and leaves every modified flag unchanged.
- R8: A `confirm` pulse while a victim is pending clears both flags of that victim and returns the block to idle.
- R9: An access always wins over any clearing (hand, periodic or confirm) of the same frame's flags in the same cycle.
- R10: `evict_done` is a one-cycle pulse. `victim_idx` and `victim_dirty` change only together with it. An eviction request made while a victim awaits confirmation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access to a resident frame occurs this cycle |
| acc_frame | input | IDX_W | Frame touched by the access |
| acc_write | input | 1 | The access modifies the frame |
| ref_clear | input | 1 | Periodic wipe of all used flags |
| evict_req | input | 1 | Request selection of a victim |
| confirm | input | 1 | Replacement of the pending victim is complete |
| evict_done | output | 1 | One-cycle pulse: victim outputs are new |
| victim_idx | output | IDX_W | Selected frame |
| victim_dirty | output | 1 | Selected frame needs write-back |

## Verification
On every cycle the assertions check several local rules. An access leaves its frame's flags set in the next cycle, even when a clear targets the same frame. A periodic clear empties the used flags. A confirmed victim loses both flags. A skipped frame moves the hand by exactly one, and the hand rests just past each victim. The done pulse lasts one cycle, and the victim outputs stay stable between pulses. Other properties show only in the bench's scenarios, by way of which frame is selected and how many cycles the selection takes. These include the wrap around a fully used ring, modified flags that outlive sweeps and periodic clears, an access racing the hand, and a request ignored while a victim is pending.

// File: rtl/clkrep_pkg.sv
package clkrep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_HOLD  = 2'd2
    } sweep_state_e;

    typedef struct packed {
        logic used;
        logic modified;
    } frame_flags_t;

    function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/frame_use_bits.sv
module frame_use_bits
    import clkrep_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 8,
    parameter int unsigned IDX_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic [IDX_W-1:0]      acc_frame,
    input  logic                  acc_write,
    input  logic                  ref_clear,
    input  logic                  hand_clr,
    input  logic [IDX_W-1:0]      hand_idx,
    input  logic                  conf_clr,
    input  logic [IDX_W-1:0]      conf_idx,
    output logic [NUM_FRAMES-1:0] used_vec,
    output logic [NUM_FRAMES-1:0] mod_vec
);

    frame_flags_t flags_q [NUM_FRAMES];
    frame_flags_t flags_d [NUM_FRAMES];

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
        logic touch;
        logic wipe_used;
        logic wipe_mod;

        assign touch     = acc_valid && (acc_frame == IDX_W'(i));
        assign wipe_mod  = conf_clr && (conf_idx == IDX_W'(i));
        assign wipe_used = ref_clear || wipe_mod ||
                           (hand_clr && (hand_idx == IDX_W'(i)));

        always_comb begin
            flags_d[i] = flags_q[i];
            if (wipe_used) flags_d[i].used = 1'b0;
            if (wipe_mod)  flags_d[i].modified = 1'b0;
            // an access overrides every clear in the same cycle
            if (touch) flags_d[i].used = 1'b1;
            if (touch && acc_write) flags_d[i].modified = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) flags_q[i] <= '0;
            else     flags_q[i] <= flags_d[i];
        end

        assign used_vec[i] = flags_q[i].used;
        assign mod_vec[i]  = flags_q[i].modified;
    end

    assert_access_sets_used_R2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> used_vec[$past(acc_frame)]);

    assert_write_sets_mod_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |=> mod_vec[$past(acc_frame)]);

    assert_clear_wipes_used_R7: assert property (@(posedge clk) disable iff (rst)
        (ref_clear && !acc_valid) |=> (used_vec == '0));

    assert_clear_keeps_mod_R7: assert property (@(posedge clk) disable iff (rst)
        (ref_clear && !conf_clr && !acc_valid) |=> $stable(mod_vec));

    assert_confirm_wipes_R8: assert property (@(posedge clk) disable iff (rst)
        (conf_clr && !(acc_valid && acc_frame == conf_idx))
        |=> (!used_vec[$past(conf_idx)] && !mod_vec[$past(conf_idx)]));

endmodule

// File: rtl/hand_sweeper.sv
module hand_sweeper
    import clkrep_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 8,
    parameter int unsigned IDX_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  evict_req,
    input  logic                  confirm,
    input  logic [NUM_FRAMES-1:0] used_vec,
    input  logic [NUM_FRAMES-1:0] mod_vec,
    output logic                  hand_clr,
    output logic [IDX_W-1:0]      hand_idx,
    output logic                  conf_clr,
    output logic [IDX_W-1:0]      conf_idx,
    output logic                  evict_done,
    output logic [IDX_W-1:0]      victim_idx,
    output logic                  victim_dirty
);

    sweep_state_e      state_q;
    logic [IDX_W-1:0]  hand_q;
    logic [IDX_W-1:0]  hand_inc;
    logic              cand_used;

    assign hand_inc  = IDX_W'(ring_next(int'(hand_q), NUM_FRAMES));
    assign cand_used = used_vec[hand_q];

    assign hand_idx = hand_q;
    assign hand_clr = (state_q == ST_SWEEP) && cand_used;
    assign conf_clr = (state_q == ST_HOLD) && confirm;
    assign conf_idx = victim_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            hand_q       <= '0;
            evict_done   <= 1'b0;
            victim_idx   <= '0;
            victim_dirty <= 1'b0;
        end else begin
            evict_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (evict_req) state_q <= ST_SWEEP;
                end
                ST_SWEEP: begin
                    hand_q <= hand_inc;
                    if (!cand_used) begin
                        evict_done   <= 1'b1;
                        victim_idx   <= hand_q;
                        victim_dirty <= mod_vec[hand_q];
                        state_q      <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (confirm) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_skip_advances_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SWEEP && cand_used)
        |=> (!evict_done && hand_q == IDX_W'(ring_next(int'($past(hand_q)), NUM_FRAMES))));

    assert_hand_past_victim_R5: assert property (@(posedge clk) disable iff (rst)
        evict_done |-> (hand_q == IDX_W'(ring_next(int'(victim_idx), NUM_FRAMES))));

    assert_victim_was_unused_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SWEEP && !cand_used) |=> (evict_done && victim_idx == $past(hand_q)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        evict_done |=> !evict_done);

    assert_victim_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !evict_done |-> ($stable(victim_idx) && $stable(victim_dirty)));

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
    import clkrep_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 8,
    localparam int unsigned IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             acc_write,
    input  logic             ref_clear,
    input  logic             evict_req,
    input  logic             confirm,
    output logic             evict_done,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_dirty
);

    logic [NUM_FRAMES-1:0] used_vec;
    logic [NUM_FRAMES-1:0] mod_vec;
    logic                  hand_clr;
    logic [IDX_W-1:0]      hand_idx;
    logic                  conf_clr;
    logic [IDX_W-1:0]      conf_idx;

    frame_use_bits #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_bits (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_frame (acc_frame),
        .acc_write (acc_write),
        .ref_clear (ref_clear),
        .hand_clr  (hand_clr),
        .hand_idx  (hand_idx),
        .conf_clr  (conf_clr),
        .conf_idx  (conf_idx),
        .used_vec  (used_vec),
        .mod_vec   (mod_vec)
    );

    hand_sweeper #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_hand (
        .clk          (clk),
        .rst          (rst),
        .evict_req    (evict_req),
        .confirm      (confirm),
        .used_vec     (used_vec),
        .mod_vec      (mod_vec),
        .hand_clr     (hand_clr),
        .hand_idx     (hand_idx),
        .conf_clr     (conf_clr),
        .conf_idx     (conf_idx),
        .evict_done   (evict_done),
        .victim_idx   (victim_idx),
        .victim_dirty (victim_dirty)
    );

endmodule

// File: tb/tb_clock_victim_sel.sv
module tb_clock_victim_sel;

    localparam int N = 8;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic         acc_valid;
    logic [W-1:0] acc_frame;
    logic         acc_write;
    logic         ref_clear;
    logic         evict_req;
    logic         confirm;
    logic         evict_done;
    logic [W-1:0] victim_idx;
    logic         victim_dirty;

    always #10 clk = ~clk;   // 50 MHz

    clock_victim_sel #(.NUM_FRAMES(N)) dut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
        .ref_clear(ref_clear), .evict_req(evict_req), .confirm(confirm),
        .evict_done(evict_done), .victim_idx(victim_idx), .victim_dirty(victim_dirty)
    );

    typedef struct {
        int    idx;
        bit    dirty;
        int    lat;
        int    start;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected victims as the design reports them
    always @(negedge clk) begin
        if (!rst && evict_done) begin
            if (exp_q.size() == 0) begin
                check("R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "victim index", int'(victim_idx), e.idx);
                check(e.tag, "victim dirty", int'(victim_dirty), int'(e.dirty));
                check(e.tag, "latency", cyc - e.start, e.lat);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic access(int f, bit wr);
        acc_valid = 1'b1; acc_frame = W'(f); acc_write = wr;
        step();
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic push_req(int idx, bit dirty, int lat, string tag);
        exp_t e;
        e.idx = idx; e.dirty = dirty; e.lat = lat; e.start = cyc; e.tag = tag;
        exp_q.push_back(e);
        evict_req = 1'b1;
    endtask

    task automatic wait_empty();
        for (int t = 0; t < 40 && exp_q.size() != 0; t++) step();
        if (exp_q.size() != 0) begin
            check("R3", "missing done", 0, 1);
            exp_q.delete();
        end
    endtask

    task automatic evict(int idx, bit dirty, int lat, string tag);
        push_req(idx, dirty, lat, tag);
        step();
        evict_req = 1'b0;
        wait_empty();
    endtask

    task automatic do_confirm();
        confirm = 1'b1;
        step();
        confirm = 1'b0;
    endtask

    initial begin
        rst = 1'b1; acc_valid = 0; acc_frame = '0; acc_write = 0;
        ref_clear = 0; evict_req = 0; confirm = 0;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1", "done after reset", int'(evict_done), 0);
        check("R1", "victim idx after reset", int'(victim_idx), 0);
        check("R1", "victim dirty after reset", int'(victim_dirty), 0);
        // R1/R3: clean ring, hand at 0
        evict(0, 0, 2, "R1");
        do_confirm();
        // R7/R6/R3: write 4, clear refs, touch 1..3
        access(4, 1);
        ref_clear = 1'b1; step(); ref_clear = 1'b0;
        access(1, 1); access(2, 0); access(3, 0);
        evict(4, 1, 5, "R7");
        do_confirm();
        // R5: next sweep starts after victim 4
        evict(5, 0, 2, "R5");
        do_confirm();
        // R4: all used, hand at 6
        for (int f = 0; f < N; f++) access(f, 0);
        evict(6, 0, 2 + N, "R4");
        do_confirm();
        // R9: access to frame 7 in the cycle the hand clears it
        access(7, 0);
        push_req(0, 0, 3, "R9");
        step();
        evict_req = 1'b0;
        acc_valid = 1'b1; acc_frame = 3'd7;
        step();
        acc_valid = 1'b0;
        wait_empty();
        do_confirm();
        for (int f = 1; f <= 6; f++) access(f, 0);
        evict(0, 0, 9, "R9");
        do_confirm();
        // R6: frame 1 still modified since its write
        evict(1, 1, 2, "R6");
        // R10: request while victim pending is ignored
        evict_req = 1'b1; step(); evict_req = 1'b0;
        begin
            int seen = 0;
            for (int t = 0; t < 6; t++) begin
                @(negedge clk);
                if (evict_done) seen++;
            end
            step();
            check("R10", "done while pending", seen, 0);
        end
        do_confirm();
        evict(2, 0, 2, "R10");
        do_confirm();
        evict(3, 0, 2, "R8");
        do_confirm();
        // R8: frame 4 modified flag wiped by earlier confirm
        evict(4, 0, 2, "R8");
        do_confirm();
        // R8: confirm wipes a used flag set while pending
        evict(5, 0, 2, "R8");
        access(5, 1);
        do_confirm();
        access(6, 0); access(7, 0);
        for (int f = 0; f <= 4; f++) access(f, 0);
        evict(5, 0, 9, "R8");
        do_confirm();
        check("R3", "leftover expectations", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule